// File: doc/BRIEF.md
# Asynchronous Host Register Port

This block is the slave side of a parallel host bus. It gives a processor with no shared clock read and write access to a bank of 32 sixteen-bit registers. The host supplies a 5-bit word address, a read/write select, an active-low select line and an active-low strobe. The host holds write data on its own bus. The block brings the three control lines into its system clock domain through two-flop synchronizers and detects each strobe falling edge. It then either commits a write or presents read data, and answers with an active-low acknowledge.

The read data bus and the acknowledge are each modelled as a value plus an output enable, in place of real tristate pins. An enable of 0 stands for high impedance. A cycle ends when the host raises the strobe, and the acknowledge is then released. The select line may stay low across any number of cycles, and every new strobe falling edge starts a new cycle. A strobe that rises before the acknowledge is given abandons the cycle, and the register bank is left untouched.

Top module: `host_reg_port`

## Requirements
- R1: `host_rd_wr` high at the strobe falling edge makes the cycle a read. Low makes it a write. A read never changes any register.
- R2: While `host_sel_n` is high, no cycle starts, no register changes, and both `host_rdata_oe` and `host_ack_oe` are 0.
- R3: `host_rdata_oe` is 0 whenever the synchronized strobe is high, even when the select line is low.
- R4: The acknowledge (`host_ack_oe`=1 with `host_ack_n`=0) appears on the 4th rising clock edge after the strobe falls. It holds until the strobe rises, and `host_ack_oe` returns to 0 within 3 clock edges after that.
- R5: Address and write data are captured at the detected strobe falling edge. The write is committed one clock before the acknowledge appears.
- R6: For a read, `host_rdata` carries the addressed register with `host_rdata_oe`=1 one clock before the acknowledge and for as long as the acknowledge is held.
- R7: With `host_sel_n` held low, consecutive strobe pulses each run a complete, independent cycle.
- R8: If the strobe rises before the acknowledge has been issued, the cycle is abandoned. Nothing is written and no acknowledge is driven.
- R9: `rst_n` low at a clock edge clears all 32 registers to 0 and returns the port to idle with both output enables at 0.
- R10: Each of the 32 addresses selects its own register. A write to one address leaves all the others unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_sel_n | input | 1 | Active-low select (asynchronous to clk) |
| host_stb_n | input | 1 | Active-low transfer strobe (asynchronous) |
| host_rd_wr | input | 1 | 1 = read, 0 = write |
| host_addr | input | 5 | Register word address |
| host_wdata | input | 16 | Write data from host |
| host_rdata | output | 16 | Read data value |
| host_rdata_oe | output | 1 | Read data drive enable (0 = high impedance) |
| host_ack_n | output | 1 | Active-low acknowledge value |
| host_ack_oe | output | 1 | Acknowledge drive enable (0 = high impedance) |

## Verification
The embedded assertions check a set of rules on every cycle. A write reaches the bank only in the cycle after a detected strobe fall. Every acknowledge is preceded by either a committed write or valid read data. The acknowledge and the read-data enable drop once the select line is seen high. A committed write lands in the addressed word. Only the bench's scenarios can show the end-to-end properties: the exact four-clock acknowledge latency, the contents of all 32 words after write and read sweeps, that abandoned or deselected cycles leave data intact, and that reset clears written words.

// File: rtl/hrp_pkg.sv
// Shared types for the asynchronous host register port.
package hrp_pkg;
    // Transfer sequencer states: wait for strobe, commit/present, acknowledge
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CAPT = 2'd1,
        ST_ACK  = 2'd2
    } hrp_state_e;
endpackage

// File: rtl/hrp_sync.sv
// Multi-stage synchronizer for a bundle of asynchronous single-bit controls.
// Assumes each bit is independent; RST_VAL sets the idle level of each bit.
module hrp_sync #(
    parameter int          WIDTH   = 3,
    parameter int          STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // First stage samples the raw asynchronous inputs
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[0] <= RST_VAL;
                    else        chain[0] <= async_in;
                end
            end else begin : g_next
                // Later stages resolve metastability of the previous one
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[s] <= RST_VAL;
                    else        chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/hrp_regbank.sv
// Bank of DEPTH words with one synchronous write port and one combinational
// read port. Assumes at most one write per clock; reset clears all words.
module hrp_regbank #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 5,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] mem [DEPTH];

    generate
        for (genvar w = 0; w < DEPTH; w++) begin : g_word
            // Each word clears on reset and loads when addressed by a write
            always_ff @(posedge clk) begin
                if (!rst_n)
                    mem[w] <= '0;
                else if (wr_en && (wr_addr == ADDR_W'(w)))
                    mem[w] <= wr_data;
            end
        end
    endgenerate

    // Read port follows the latched cycle address
    assign rd_data = mem[rd_addr];

    // R5
    write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (mem[$past(wr_addr)] == $past(wr_data)));
endmodule

// File: rtl/hrp_seq.sv
// Transfer sequencer: detects strobe falls on synchronized controls, latches
// address/data, commits writes or presents reads, and drives the acknowledge.
// Assumes the host holds address and write data stable while strobe is low.
module hrp_seq
    import hrp_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_s,
    input  logic              stb_s,
    input  logic              rw_s,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic              wr_en,
    output logic [ADDR_W-1:0] cyc_addr,
    output logic [DATA_W-1:0] cyc_wdata,
    output logic              rdata_oe,
    output logic              ack_n,
    output logic              ack_oe
);
    hrp_state_e state;
    logic       stb_prev;
    logic       is_read;
    logic       stb_fall;
    logic       cyc_end;

    // Remember the previous synchronized strobe for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) stb_prev <= 1'b1;
        else        stb_prev <= stb_s;
    end

    assign stb_fall = stb_prev && !stb_s && !sel_s;
    assign cyc_end  = stb_s || sel_s;

    // Sequence one transfer and latch its address, data and direction
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cyc_addr  <= '0;
            cyc_wdata <= '0;
            is_read   <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: if (stb_fall) begin
                    state     <= ST_CAPT;
                    cyc_addr  <= host_addr;
                    cyc_wdata <= host_wdata;
                    is_read   <= rw_s;
                end
                ST_CAPT: state <= cyc_end ? ST_IDLE : ST_ACK;
                ST_ACK:  if (cyc_end) state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Commit a write only if the strobe is still low in the capture cycle
    assign wr_en    = (state == ST_CAPT) && !is_read && !cyc_end;
    // Read data driven from capture onward while strobe and select are low
    assign rdata_oe = (state != ST_IDLE) && is_read && !cyc_end;
    // Acknowledge value and enable
    assign ack_n    = (state != ST_ACK);
    assign ack_oe   = (state == ST_ACK) && !sel_s;

    // R5
    write_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $past(stb_fall));

    // R6
    read_valid_before_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(state == ST_ACK) && is_read) |-> $past(rdata_oe));

    // R5
    write_before_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(state == ST_ACK) && !is_read) |-> $past(wr_en));

    // R4
    ack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_ACK) && stb_s) |=> !ack_oe);

    // R2
    deselect_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_s |=> (!ack_oe && !rdata_oe && !wr_en));
endmodule

// File: rtl/host_reg_port.sv
// Top of the asynchronous host register port. Synchronizes host controls,
// sequences transfers and returns read data / acknowledge as value+enable.
// Assumes address and write data are stable while the strobe is low.
module host_reg_port #(
    parameter int DATA_W      = 16,
    parameter int ADDR_W      = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_sel_n,
    input  logic              host_stb_n,
    input  logic              host_rd_wr,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              host_rdata_oe,
    output logic              host_ack_n,
    output logic              host_ack_oe
);
    localparam int CTRL_W = 3;

    logic [CTRL_W-1:0] ctrl_sync;
    logic              wr_en;
    logic [ADDR_W-1:0] cyc_addr;
    logic [DATA_W-1:0] cyc_wdata;

    hrp_sync #(
        .WIDTH   (CTRL_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b111)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({host_rd_wr, host_stb_n, host_sel_n}),
        .sync_out (ctrl_sync)
    );

    hrp_seq #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_s      (ctrl_sync[0]),
        .stb_s      (ctrl_sync[1]),
        .rw_s       (ctrl_sync[2]),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .wr_en      (wr_en),
        .cyc_addr   (cyc_addr),
        .cyc_wdata  (cyc_wdata),
        .rdata_oe   (host_rdata_oe),
        .ack_n      (host_ack_n),
        .ack_oe     (host_ack_oe)
    );

    hrp_regbank #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (cyc_addr),
        .wr_data (cyc_wdata),
        .rd_addr (cyc_addr),
        .rd_data (host_rdata)
    );
endmodule

// File: tb/tb_host_reg_port.sv
// Near-exhaustive bench: sweeps all 32 addresses with computed patterns and
// exercises deselect, abandon, back-to-back and reset corner cases.
module tb_host_reg_port;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        host_sel_n, host_stb_n, host_rd_wr;
    logic [4:0]  host_addr;
    logic [15:0] host_wdata;
    logic [15:0] host_rdata;
    logic        host_rdata_oe, host_ack_n, host_ack_oe;

    int checks = 0;
    int errors = 0;
    logic [15:0] model [32];

    always #10 clk = ~clk;   // 50 MHz

    host_reg_port dut (
        .clk(clk), .rst_n(rst_n), .host_sel_n(host_sel_n), .host_stb_n(host_stb_n),
        .host_rd_wr(host_rd_wr), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .host_rdata_oe(host_rdata_oe),
        .host_ack_n(host_ack_n), .host_ack_oe(host_ack_oe)
    );

    function automatic logic [15:0] pat(input int a, input int seed);
        return 16'((a * 32'h1357) ^ seed ^ (a << 11));
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One strobe cycle with select low; returns captured read data
    task automatic xfer(input bit rd, input int a, input logic [15:0] wd,
                        output logic [15:0] rdv);
        int n = 0;
        bit prev_oe = 1'b0;
        bit got = 1'b0;
        rdv = '0;
        @(negedge clk);
        host_sel_n = 1'b0; host_rd_wr = rd; host_addr = 5'(a); host_wdata = wd;
        host_stb_n = 1'b0;
        for (int i = 1; i <= 12 && !got; i++) begin
            @(negedge clk);
            n = i;
            if (host_ack_oe && !host_ack_n) got = 1'b1;
            else prev_oe = host_rdata_oe;
        end
        // R4: acknowledge four clocks after the strobe falls
        check(got && n == 4, "R4 ack latency", n, 4);
        if (rd) begin
            // R6: read data valid one clock ahead of and during the acknowledge
            check(prev_oe && host_rdata_oe, "R6 rdata_oe before/with ack",
                  {prev_oe, host_rdata_oe}, 3);
            rdv = host_rdata;
        end else begin
            // R1: write cycle never drives the data bus
            check(!host_rdata_oe, "R1 no rdata_oe on write", host_rdata_oe, 0);
        end
        host_stb_n = 1'b1;
        got = 1'b0;
        n = 0;
        for (int i = 1; i <= 8 && !got; i++) begin
            @(negedge clk);
            n = i;
            if (!host_ack_oe) got = 1'b1;
        end
        // R4: release within three clocks; R3: no data drive with strobe high
        check(got && n <= 3, "R4 ack release", n, 3);
        check(!host_rdata_oe, "R3 rdata_oe off after strobe high", host_rdata_oe, 0);
    endtask

    task automatic bus_wr(input int a, input logic [15:0] wd);
        logic [15:0] dummy;
        xfer(1'b0, a, wd, dummy);
        model[a] = wd;
    endtask

    task automatic bus_rd_chk(input int a, input string req);
        logic [15:0] v;
        xfer(1'b1, a, 16'hDEAD, v);
        check(v == model[a], req, v, model[a]);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        host_sel_n = 1'b1; host_stb_n = 1'b1; host_rd_wr = 1'b1;
        host_addr = '0; host_wdata = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        for (int a = 0; a < 32; a++) model[a] = '0;
        repeat (3) @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        // R9: reset state of outputs
        check(!host_ack_oe && !host_rdata_oe, "R9 outputs idle after reset",
              {host_ack_oe, host_rdata_oe}, 0);
        // R9: every word reads zero after reset
        for (int a = 0; a < 32; a++) bus_rd_chk(a, "R9 reset value");

        // R10 / R1: write every address with a distinct pattern, then read all
        for (int a = 0; a < 32; a++) bus_wr(a, pat(a, 16'hA5C3));
        for (int a = 31; a >= 0; a--) bus_rd_chk(a, "R10 sweep readback");

        // R1: reads do not disturb data (second read pass)
        for (int a = 0; a < 32; a += 5) bus_rd_chk(a, "R1 read is non-destructive");

        // R10: single overwrite leaves neighbours intact
        bus_wr(9, 16'h0F0F);
        for (int a = 7; a <= 11; a++) bus_rd_chk(a, "R10 isolation");

        // R7: back-to-back cycles with select held low
        for (int a = 0; a < 32; a++) bus_wr(a, pat(a, 16'h3C5A));
        for (int a = 0; a < 32; a++) bus_rd_chk(a, "R7 back-to-back");

        // R2: strobe pulses with select high do nothing
        @(negedge clk);
        host_sel_n = 1'b1; host_rd_wr = 1'b0; host_addr = 5'd3; host_wdata = 16'hBEEF;
        host_stb_n = 1'b0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            check(!host_ack_oe && !host_rdata_oe, "R2 deselected quiet",
                  {host_ack_oe, host_rdata_oe}, 0);
        end
        host_stb_n = 1'b1;
        repeat (3) @(negedge clk);
        bus_rd_chk(3, "R2 no write while deselected");

        // R3: read-direction strobe high with select low never drives data
        @(negedge clk);
        host_sel_n = 1'b0; host_rd_wr = 1'b1;
        repeat (4) @(negedge clk);
        check(!host_rdata_oe && !host_ack_oe, "R3 idle select low",
              {host_rdata_oe, host_ack_oe}, 0);

        // R8: one-clock strobe pulse is abandoned before acknowledge
        @(negedge clk);
        host_sel_n = 1'b0; host_rd_wr = 1'b0; host_addr = 5'd20; host_wdata = 16'h1234;
        host_stb_n = 1'b0;
        @(negedge clk);
        host_stb_n = 1'b1;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            check(!host_ack_oe, "R8 no ack on abandon", host_ack_oe, 0);
        end
        bus_rd_chk(20, "R8 abandoned write not committed");

        // R5: data captured at strobe fall even if bus changes later? (host holds;
        // verify commit value equals value present at the fall)
        bus_wr(14, 16'hC0DE);
        bus_rd_chk(14, "R5 write commit");

        // R9: reset clears written words
        do_reset();
        for (int a = 0; a < 32; a += 3) bus_rd_chk(a, "R9 cleared by reset");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule